// File: doc/BRIEF.md
# Parallel Command Decoder for a Full-Speed USB Device Controller

This block is the command front end that a host processor reaches over a parallel bus. A command strobe latches an opcode byte. The opcode is decoded into a target register, a transfer direction (none, read or write) and a fixed byte count. The block then steps through the data phase one bus cycle at a time. On an 8-bit bus each cycle carries one byte. On a 16-bit bus each cycle carries two bytes, with the lower byte on bits 7:0. Multi-byte values go least significant byte first.

The status, error-code, frame-number and interrupt registers are plain storage. A test hook port loads them. The chip ID is a parameter. The scratch register is written and read over the bus, and an unlock code is captured from a two-byte write. Unstall and setup-acknowledge commands produce one-cycle strobes. Opcodes the block does not know set a sticky error flag.

Top module: `pcmd_top`

## Requirements
- R1: After reset, busy, err_flag, both strobes, rd_data and unlock_val are all zero, and the scratch register reads back 0x0000.
- R2: Opcodes 0x82..0x8F raise unstall_stb for exactly one cycle, starting the cycle after the command strobe. unstall_ep carries opcode minus 0x81 (1..14). There is no data phase.
- R3: Opcode 0xF4 raises setup_ack_stb for one cycle, starting the cycle after the command strobe, with no data phase.
- R4: Opcodes 0xD0..0xDF read one status byte from slot opcode[3:0]. Slot 0 is endpoint 0 OUT, slot 1 is endpoint 0 IN, and slot k+1 is endpoint k. Reading does not change the stored byte. Storage is loaded via hook_we with hook_sel 0x00..0x0F, which selects status slot hook_sel[3:0] and takes hook_data[7:0].
- R5: Opcodes 0xA0..0xAF read one error-code byte from slot opcode[3:0], using the same slot numbering as R4. These bytes are loaded with hook_sel 0x10..0x1F.
- R6: Opcode 0xB2 writes the 16-bit scratch register with two bytes, low byte first. Opcode 0xB3 reads it back as two bytes.
- R7: Opcode 0xB0 is a two-byte write. unlock_val takes the new value at the edge of the final data cycle and does not change before that edge.
- R8: Opcode 0xB4 reads FRAME_BYTES bytes of the frame number (hook_sel 0x20, hook_data[15:0]). Opcode 0xB5 reads the two-byte CHIP_ID. Opcode 0xC0 reads the four-byte interrupt register (hook_sel 0x21, hook_data[31:0]). All three send the low byte first.
- R9: With bus16=1, an N-byte transfer takes (N+1)/2 data cycles. Each cycle moves the next byte on bits 7:0 and the one after it on bits 15:8. The upper byte is driven to zero when it lies beyond N.
- R10: Any other opcode starts no data phase and sets err_flag from the next cycle on. Only reset clears err_flag.
- R11: A command strobe during a data phase ends that phase and decodes the new opcode. An unfinished write commits nothing.
- R12: data_rd and data_wr are ignored when idle or when they do not match the current direction. The byte position does not advance and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus16 | input | 1 | 1 selects 16-bit data cycles, 0 selects 8-bit |
| cmd_stb | input | 1 | Latch cmd_byte as a new command |
| cmd_byte | input | 8 | Opcode |
| data_rd | input | 1 | Host consumes the data presented on rd_data |
| data_wr | input | 1 | Host supplies wr_data |
| wr_data | input | 16 | Write data, low byte on bits 7:0 |
| rd_data | output | 16 | Read data for the current data cycle, zero otherwise |
| busy | output | 1 | Data phase in progress |
| unstall_stb | output | 1 | One-cycle unstall request |
| unstall_ep | output | 4 | Endpoint number for unstall_stb |
| setup_ack_stb | output | 1 | One-cycle setup acknowledge |
| err_flag | output | 1 | Sticky unknown-opcode flag |
| unlock_val | output | 16 | Last completed unlock code |
| hook_we | input | 1 | Test hook write enable |
| hook_sel | input | 6 | Test hook register select |
| hook_data | input | 32 | Test hook write data |

## Verification
The bench builds the block with FRAME_BYTES=2 and the default CHIP_ID. With these values a frame read takes two bytes, so on the 16-bit bus it fits in one word. The four-byte interrupt read then becomes the only transfer that needs two word cycles. A status read on the 16-bit bus exercises the zero upper byte. Both bus widths are run with the same reference model, so the odd-length packing and the abort of partly transferred words are covered.

// File: rtl/pcmd_pkg.sv
`timescale 1ns/1ps
package pcmd_pkg;

  localparam int SLOTS = 16;

  typedef enum logic [1:0] {XF_NONE = 2'd0, XF_READ = 2'd1, XF_WRITE = 2'd2} xfer_e;

  typedef enum logic [3:0] {
    TG_NONE, TG_UNSTALL, TG_SETUP, TG_STAT, TG_ERR, TG_UNLOCK,
    TG_SCR_W, TG_SCR_R, TG_FRAME, TG_CHIP, TG_INTR, TG_BAD
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    xfer_e      xf;
    logic [2:0] nbytes;
    logic [3:0] slot;
  } cmd_t;

  function automatic cmd_t mk_cmd(input tgt_e t, input xfer_e x,
                                  input logic [2:0] n, input logic [3:0] s);
    cmd_t c;
    c.tgt = t; c.xf = x; c.nbytes = n; c.slot = s;
    return c;
  endfunction

  function automatic cmd_t decode_op(input logic [7:0] op, input logic [2:0] frame_n);
    cmd_t c;
    c = mk_cmd(TG_BAD, XF_NONE, 3'd0, 4'd0);
    case (op[7:4])
      4'h8: if (op[3:1] != 3'b000) c = mk_cmd(TG_UNSTALL, XF_NONE, 3'd0, op[3:0] - 4'd1);
      4'hD: c = mk_cmd(TG_STAT, XF_READ, 3'd1, op[3:0]);
      4'hA: c = mk_cmd(TG_ERR, XF_READ, 3'd1, op[3:0]);
      4'hB: begin
        case (op[3:0])
          4'h0: c = mk_cmd(TG_UNLOCK, XF_WRITE, 3'd2, 4'd0);
          4'h2: c = mk_cmd(TG_SCR_W, XF_WRITE, 3'd2, 4'd0);
          4'h3: c = mk_cmd(TG_SCR_R, XF_READ, 3'd2, 4'd0);
          4'h4: c = mk_cmd(TG_FRAME, XF_READ, frame_n, 4'd0);
          4'h5: c = mk_cmd(TG_CHIP, XF_READ, 3'd2, 4'd0);
          default: c = mk_cmd(TG_BAD, XF_NONE, 3'd0, 4'd0);
        endcase
      end
      4'hC: if (op[3:0] == 4'h0) c = mk_cmd(TG_INTR, XF_READ, 3'd4, 4'd0);
      4'hF: if (op[3:0] == 4'h4) c = mk_cmd(TG_SETUP, XF_NONE, 3'd0, 4'd0);
      default: c = mk_cmd(TG_BAD, XF_NONE, 3'd0, 4'd0);
    endcase
    return c;
  endfunction

  // bytes moved by one data cycle
  function automatic logic [2:0] step_bytes(input logic wide);
    return wide ? 3'd2 : 3'd1;
  endfunction

  // byte idx of a little-endian 32-bit value
  function automatic logic [7:0] byte_at(input logic [31:0] v, input logic [2:0] idx);
    logic [31:0] s;
    s = v >> {idx[1:0], 3'b000};
    return s[7:0];
  endfunction

endpackage

// File: rtl/pcmd_decode.sv
`timescale 1ns/1ps
module pcmd_decode import pcmd_pkg::*; #(
  parameter int FRAME_BYTES = 2
) (
  input  logic [7:0] op,
  output cmd_t       dec
);
  localparam logic [2:0] FRAME_N = 3'(FRAME_BYTES);

  assign dec = decode_op(op, FRAME_N);

  always_comb begin
    a_r9_len_fits: assert (dec.nbytes <= 3'd4);
  end
endmodule

// File: rtl/pcmd_store.sv
`timescale 1ns/1ps
module pcmd_store import pcmd_pkg::*; #(
  parameter logic [15:0] CHIP_ID = 16'h3A21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hook_we,
  input  logic [5:0]  hook_sel,
  input  logic [31:0] hook_data,
  input  logic        commit_en,
  input  tgt_e        commit_tgt,
  input  logic [15:0] commit_val,
  input  tgt_e        rd_tgt,
  input  logic [3:0]  rd_slot,
  output logic [31:0] val32,
  output logic [15:0] unlock_val
);
  logic [SLOTS-1:0][7:0] stat_q, err_q;
  logic [15:0] frame_q, scr_q, unl_q;
  logic [31:0] intr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0; err_q <= '0; frame_q <= '0;
      intr_q <= '0; scr_q <= '0; unl_q <= '0;
    end else begin
      if (hook_we) begin
        case (hook_sel[5:4])
          2'b00: stat_q[hook_sel[3:0]] <= hook_data[7:0];
          2'b01: err_q[hook_sel[3:0]]  <= hook_data[7:0];
          2'b10: begin
            if (hook_sel[3:0] == 4'h0) frame_q <= hook_data[15:0];
            if (hook_sel[3:0] == 4'h1) intr_q  <= hook_data;
          end
          default: ;
        endcase
      end
      if (commit_en && commit_tgt == TG_SCR_W)  scr_q <= commit_val;
      if (commit_en && commit_tgt == TG_UNLOCK) unl_q <= commit_val;
    end
  end

  always_comb begin
    case (rd_tgt)
      TG_STAT:  val32 = {24'h0, stat_q[rd_slot]};
      TG_ERR:   val32 = {24'h0, err_q[rd_slot]};
      TG_SCR_R: val32 = {16'h0, scr_q};
      TG_FRAME: val32 = {16'h0, frame_q};
      TG_CHIP:  val32 = {16'h0, CHIP_ID};
      TG_INTR:  val32 = intr_q;
      default:  val32 = 32'h0;
    endcase
  end

  assign unlock_val = unl_q;

  // R4/R5: reads never alter status or error storage
  a_r4_read_is_copy: assert property (@(posedge clk) disable iff (!rst_n)
    !hook_we |=> ($stable(stat_q) && $stable(err_q)));
  // R12: registers written over the bus change only on a completed write
  a_r12_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> ($stable(scr_q) && $stable(unl_q)));
endmodule

// File: rtl/pcmd_phase.sv
`timescale 1ns/1ps
module pcmd_phase import pcmd_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus16,
  input  logic        cmd_stb,
  input  cmd_t        dec,
  input  logic        data_rd,
  input  logic        data_wr,
  input  logic [15:0] wr_data,
  input  logic [31:0] val32,
  output cmd_t        cur,
  output logic        busy,
  output logic [15:0] rd_data,
  output logic        unstall_stb,
  output logic [3:0]  unstall_ep,
  output logic        setup_ack_stb,
  output logic        err_flag,
  output logic        commit_en,
  output logic [15:0] commit_val
);
  logic [2:0]  cnt, step, nxt_cnt;
  logic        last, rd_go, wr_go;
  logic [15:0] wbuf, wbuf_nxt;
  logic [7:0]  lo, hi;

  assign step    = step_bytes(bus16);
  assign nxt_cnt = cnt + step;
  assign last    = nxt_cnt >= cur.nbytes;
  assign rd_go   = busy && data_rd && !cmd_stb && cur.xf == XF_READ;
  assign wr_go   = busy && data_wr && !cmd_stb && cur.xf == XF_WRITE;

  always_comb begin
    lo = byte_at(val32, cnt);
    hi = ((cnt + 3'd1) < cur.nbytes) ? byte_at(val32, cnt + 3'd1) : 8'h00;
    rd_data = 16'h0;
    if (busy && cur.xf == XF_READ) rd_data = bus16 ? {hi, lo} : {8'h00, lo};
  end

  always_comb begin
    wbuf_nxt = wbuf;
    if (cnt[0]) wbuf_nxt[15:8] = wr_data[7:0];
    else begin
      wbuf_nxt[7:0] = wr_data[7:0];
      if (bus16) wbuf_nxt[15:8] = wr_data[15:8];
    end
  end

  assign commit_en  = wr_go && last;
  assign commit_val = wbuf_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= mk_cmd(TG_NONE, XF_NONE, 3'd0, 4'd0);
      cnt <= '0; busy <= 1'b0; wbuf <= '0; err_flag <= 1'b0;
      unstall_stb <= 1'b0; unstall_ep <= '0; setup_ack_stb <= 1'b0;
    end else begin
      unstall_stb   <= 1'b0;
      setup_ack_stb <= 1'b0;
      if (cmd_stb) begin
        cur           <= dec;
        cnt           <= '0;
        wbuf          <= '0;
        busy          <= dec.xf != XF_NONE;
        unstall_stb   <= dec.tgt == TG_UNSTALL;
        setup_ack_stb <= dec.tgt == TG_SETUP;
        if (dec.tgt == TG_UNSTALL) unstall_ep <= dec.slot;
        if (dec.tgt == TG_BAD) err_flag <= 1'b1;
      end else if (rd_go) begin
        cnt <= nxt_cnt;
        if (last) busy <= 1'b0;
      end else if (wr_go) begin
        cnt  <= nxt_cnt;
        wbuf <= wbuf_nxt;
        if (last) busy <= 1'b0;
      end
    end
  end

  a_r2_ep_range: assert property (@(posedge clk) disable iff (!rst_n)
    unstall_stb |-> (unstall_ep >= 4'd1 && unstall_ep <= 4'd14));
  a_r3_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unstall_stb, setup_ack_stb}));
  a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    unstall_stb |=> (!unstall_stb || $past(cmd_stb)));
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < cur.nbytes));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r10_bad_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && dec.tgt == TG_BAD) |=> (!busy && err_flag));
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_stb && dec.xf == XF_NONE) |=> !busy);
  a_r7_commit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> !busy);
endmodule

// File: rtl/pcmd_top.sv
`timescale 1ns/1ps
module pcmd_top import pcmd_pkg::*; #(
  parameter int          FRAME_BYTES = 2,
  parameter logic [15:0] CHIP_ID     = 16'h3A21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus16,
  input  logic        cmd_stb,
  input  logic [7:0]  cmd_byte,
  input  logic        data_rd,
  input  logic        data_wr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        unstall_stb,
  output logic [3:0]  unstall_ep,
  output logic        setup_ack_stb,
  output logic        err_flag,
  output logic [15:0] unlock_val,
  input  logic        hook_we,
  input  logic [5:0]  hook_sel,
  input  logic [31:0] hook_data
);
  cmd_t        dec, cur;
  logic [31:0] val32;
  logic        commit_en;
  logic [15:0] commit_val;

  pcmd_decode #(.FRAME_BYTES(FRAME_BYTES)) u_dec (.op(cmd_byte), .dec(dec));

  pcmd_store #(.CHIP_ID(CHIP_ID)) u_store (
    .clk(clk), .rst_n(rst_n), .hook_we(hook_we), .hook_sel(hook_sel),
    .hook_data(hook_data), .commit_en(commit_en), .commit_tgt(cur.tgt),
    .commit_val(commit_val), .rd_tgt(cur.tgt), .rd_slot(cur.slot),
    .val32(val32), .unlock_val(unlock_val));

  pcmd_phase u_phase (
    .clk(clk), .rst_n(rst_n), .bus16(bus16), .cmd_stb(cmd_stb), .dec(dec),
    .data_rd(data_rd), .data_wr(data_wr), .wr_data(wr_data), .val32(val32),
    .cur(cur), .busy(busy), .rd_data(rd_data), .unstall_stb(unstall_stb),
    .unstall_ep(unstall_ep), .setup_ack_stb(setup_ack_stb), .err_flag(err_flag),
    .commit_en(commit_en), .commit_val(commit_val));
endmodule

// File: tb/tb_pcmd_top.sv
`timescale 1ns/1ps
module tb_pcmd_top;
  localparam int          FB   = 2;
  localparam logic [15:0] CHIP = 16'h3A21;

  logic clk = 1'b0, rst_n = 1'b0, bus16 = 1'b0, cmd_stb = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic data_rd = 1'b0, data_wr = 1'b0, hook_we = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [5:0]  hook_sel = 6'h0;
  logic [31:0] hook_data = 32'h0;
  logic [15:0] rd_data, unlock_val;
  logic busy, unstall_stb, setup_ack_stb, err_flag;
  logic [3:0] unstall_ep;

  pcmd_top #(.FRAME_BYTES(FB), .CHIP_ID(CHIP)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  // reference model
  logic [7:0]  m_stat[16], m_errc[16];
  logic [15:0] m_frame, m_scr, m_unl;
  logic [31:0] m_intr;
  logic [7:0]  m_q[$], m_w[$];
  bit m_busy, m_err, m_us, m_sa;
  int m_dir, m_len, m_tgt, m_uep;

  task automatic load(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) m_q.push_back(v[8*i +: 8]);
    m_dir = 1; m_busy = 1;
  endtask

  always @(posedge clk) begin
    logic [7:0] op;
    m_us = 0; m_sa = 0;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_stat[i] = 0; m_errc[i] = 0; end
      m_frame = 0; m_scr = 0; m_unl = 0; m_intr = 0;
      m_q.delete(); m_w.delete(); m_busy = 0; m_err = 0; m_dir = 0; m_uep = 0;
    end else begin
      if (hook_we) begin
        if (hook_sel < 6'h10) m_stat[hook_sel] = hook_data[7:0];
        else if (hook_sel < 6'h20) m_errc[hook_sel - 6'h10] = hook_data[7:0];
        else if (hook_sel == 6'h20) m_frame = hook_data[15:0];
        else if (hook_sel == 6'h21) m_intr = hook_data;
      end
      if (cmd_stb) begin
        op = cmd_byte;
        m_busy = 0; m_dir = 0; m_q.delete(); m_w.delete();
        if (op >= 8'h82 && op <= 8'h8F) begin m_us = 1; m_uep = op - 8'h81; end
        else if (op == 8'hF4) m_sa = 1;
        else if (op >= 8'hD0) begin
          if (op <= 8'hDF) load({24'h0, m_stat[op - 8'hD0]}, 1); else m_err = 1;
        end
        else if (op >= 8'hA0 && op <= 8'hAF) load({24'h0, m_errc[op - 8'hA0]}, 1);
        else if (op == 8'hB0 || op == 8'hB2) begin
          m_dir = 2; m_len = 2; m_busy = 1; m_tgt = (op == 8'hB0) ? 1 : 2;
        end
        else if (op == 8'hB3) load({16'h0, m_scr}, 2);
        else if (op == 8'hB4) load({16'h0, m_frame}, FB);
        else if (op == 8'hB5) load({16'h0, CHIP}, 2);
        else if (op == 8'hC0) load(m_intr, 4);
        else m_err = 1;
      end else if (data_rd && m_busy && m_dir == 1) begin
        void'(m_q.pop_front());
        if (bus16 && m_q.size() > 0) void'(m_q.pop_front());
        if (m_q.size() == 0) m_busy = 0;
      end else if (data_wr && m_busy && m_dir == 2) begin
        m_w.push_back(wr_data[7:0]);
        if (bus16 && m_w.size() < m_len) m_w.push_back(wr_data[15:8]);
        if (m_w.size() >= m_len) begin
          m_busy = 0;
          if (m_tgt == 1) m_unl = {m_w[1], m_w[0]}; else m_scr = {m_w[1], m_w[0]};
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [15:0] e;
    if (rst_n && !done) begin
      chk(busy === m_busy, "busy", busy, m_busy);
      chk(err_flag === m_err, "err_flag", err_flag, m_err);
      chk(unstall_stb === m_us, "unstall_stb", unstall_stb, m_us);
      if (m_us) chk(unstall_ep === 4'(m_uep), "unstall_ep", unstall_ep, m_uep);
      chk(setup_ack_stb === m_sa, "setup_ack_stb", setup_ack_stb, m_sa);
      chk(unlock_val === m_unl, "unlock_val", unlock_val, m_unl);
      if (m_busy && m_dir == 1) begin
        e = {(bus16 && m_q.size() > 1) ? m_q[1] : 8'h00, m_q[0]};
        chk(rd_data === e, "rd_data", rd_data, e);
      end
    end
  end

  // drivers, each starts and ends at a falling edge
  task automatic cmd(input logic [7:0] op);
    cmd_stb = 1; cmd_byte = op; @(negedge clk); cmd_stb = 0;
  endtask
  task automatic rd_chk(input logic [15:0] exp);
    chk(rd_data === exp, "rd_data direct", rd_data, exp);
    data_rd = 1; @(negedge clk); data_rd = 0;
  endtask
  task automatic wr(input logic [15:0] d);
    data_wr = 1; wr_data = d; @(negedge clk); data_wr = 0;
  endtask
  task automatic hook(input logic [5:0] s, input logic [31:0] d);
    hook_we = 1; hook_sel = s; hook_data = d; @(negedge clk); hook_we = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    cur_req = "R1";
    chk(busy === 0 && err_flag === 0 && unlock_val === 0, "reset outputs",
        {busy, err_flag, unlock_val}, 0);
    chk(rd_data === 0, "reset rd_data", rd_data, 0);
    cmd(8'hB3); rd_chk(16'h0000); rd_chk(16'h0000);

    for (int i = 0; i < 16; i++) hook(6'(i), 32'h40 + i);
    for (int i = 0; i < 16; i++) hook(6'(16 + i), 32'hE0 + i);
    hook(6'h20, 32'h0000_05A7);
    hook(6'h21, 32'h8877_6655);

    cur_req = "R2";
    cmd(8'h82); chk(unstall_stb === 1 && unstall_ep === 4'd1, "ep1", unstall_ep, 1);
    idle(1);    chk(unstall_stb === 0, "pulse width", unstall_stb, 0);
    cmd(8'h8F); chk(unstall_ep === 4'd14, "ep14", unstall_ep, 14);
    chk(busy === 0, "no data phase", busy, 0);
    cur_req = "R3";
    cmd(8'hF4); chk(setup_ack_stb === 1, "setup ack", setup_ack_stb, 1);
    idle(1);    chk(setup_ack_stb === 0, "setup ack pulse", setup_ack_stb, 0);

    cur_req = "R4";
    cmd(8'hD0); rd_chk(16'h0040);
    cmd(8'hD5); rd_chk(16'h0045);
    cmd(8'hD5); rd_chk(16'h0045);
    cmd(8'hDF); rd_chk(16'h004F);
    cur_req = "R5";
    cmd(8'hA1); rd_chk(16'h00E1);
    cmd(8'hAF); rd_chk(16'h00EF);

    cur_req = "R6";
    cmd(8'hB2); wr(16'h0034); wr(16'h0012);
    cmd(8'hB3); rd_chk(16'h0034); rd_chk(16'h0012);
    cur_req = "R7";
    cmd(8'hB0); wr(16'h00CD);
    chk(unlock_val === 16'h0000, "before last", unlock_val, 0);
    wr(16'h00AB);
    chk(unlock_val === 16'hABCD, "after last", unlock_val, 16'hABCD);
    cur_req = "R8";
    cmd(8'hB4); rd_chk(16'h00A7); rd_chk(16'h0005);
    cmd(8'hB5); rd_chk(16'h0021); rd_chk(16'h003A);
    cmd(8'hC0); rd_chk(16'h0055); rd_chk(16'h0066); rd_chk(16'h0077); rd_chk(16'h0088);

    cur_req = "R12";
    data_rd = 1; idle(1); data_rd = 0;
    data_wr = 1; wr_data = 16'hFFFF; idle(1); data_wr = 0;
    cmd(8'hB3); wr(16'hFFFF); rd_chk(16'h0034); rd_chk(16'h0012);
    cmd(8'hB2); data_rd = 1; idle(1); data_rd = 0; wr(16'h0077); wr(16'h0066);
    cmd(8'hB3); rd_chk(16'h0077); rd_chk(16'h0066);

    cur_req = "R11";
    cmd(8'hB2); wr(16'h0099); cmd(8'hB3); rd_chk(16'h0077); rd_chk(16'h0066);
    cmd(8'hC0); rd_chk(16'h0055); cmd(8'hD2); rd_chk(16'h0042);
    cmd(8'hB5); cmd(8'h85); chk(unstall_ep === 4'd4 && busy === 0, "abort to unstall", unstall_ep, 4);

    cur_req = "R10";
    chk(err_flag === 0, "clear before", err_flag, 0);
    cmd(8'h00); chk(err_flag === 1 && busy === 0, "unknown 0x00", err_flag, 1);
    cmd(8'hB1); cmd(8'h81); cmd(8'hD3); rd_chk(16'h0043);
    chk(err_flag === 1, "sticky", err_flag, 1);

    cur_req = "R9";
    bus16 = 1; idle(1);
    cmd(8'hD3); rd_chk(16'h0043);
    cmd(8'hC0); rd_chk(16'h6655); rd_chk(16'h8877);
    chk(busy === 0, "two word cycles", busy, 0);
    cmd(8'hB2); wr(16'hBEEF);
    chk(busy === 0, "one word write", busy, 0);
    cmd(8'hB3); rd_chk(16'hBEEF);
    cmd(8'hB0); wr(16'h1357);
    chk(unlock_val === 16'h1357, "word unlock", unlock_val, 16'h1357);
    cmd(8'hB4); rd_chk(16'h05A7);
    cmd(8'hC0); cmd(8'hB5); rd_chk(16'h3A21);
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule